// File: doc/BRIEF.md
# Reloadable Event/Delay Down-Counter Timer

This block is one 8-bit timer channel. A binary down counter is paired with a separate reload register. While the channel runs, the counter steps down once per tick. A tick is either one period of a prescaled clock (delay mode) or one qualifying edge on an auxiliary input pin (event-count mode). In event-count mode a polarity bit selects which edge qualifies. When the counter passes from 01 it reloads from the reload register, raises a one-cycle timeout pulse and toggles an output line.

Software drives the block through three synchronous strobes:
- A data write loads the reload register. While the channel is stopped, the same write also loads the counter. While it runs, the new value waits for the next reload.
- A control write sets the mode, the event polarity and a bit that clears the output line.
- A rising edge on the read strobe captures the counter value into the read register, which holds it until the next rising edge.

Top module: `evt_dly_timer`

## Requirements
- R1: After reset the counter, reload register, read register, timeout and output line are all 0, and the mode is stopped.
- R2: With mode code 000 (stopped), a data write loads both the reload register and the counter with the written value on the same clock edge.
- R3: While running, a data write updates only the reload register. The counter takes the new value at its next pass from 01. A write on the same edge as that pass reloads the written value.
- R4: Mode codes 001 to 110 select delay mode with tick periods of 4, 10, 16, 50, 64 and 100 clocks. The prescaler restarts from zero each time the channel leaves the stopped state.
- R5: Mode code 111 selects event-count mode. Control bit 3 set to 1 counts rising edges of aux_in, and set to 0 counts falling edges. aux_in passes through a two-flop synchronizer first.
- R6: In event-count mode, a control write that flips bit 3 produces one count when aux_in already equals the new bit 3 value, because detection acts on the input combined with the polarity bit.
- R7: A tick with the counter at 01 reloads the counter from the reload register. On the next clock the block asserts timeout for exactly one cycle and toggles out_line.
- R8: A reload value of 00 gives 256 ticks between timeouts.
- R9: A rising edge of rd_strobe captures the counter value into rdata. rdata is otherwise unchanged.
- R10: A control write with bit 4 set drives out_line to 0, even if a toggle falls on the same edge.
- R11: While stopped, the counter holds its value and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_data | input | 1 | Data (reload) register write strobe |
| wr_ctrl | input | 1 | Control register write strobe |
| wdata | input | 8 | Write data: control bits [2:0] mode, [3] polarity, [4] clear output |
| rd_strobe | input | 1 | Read capture strobe, active on its rising edge |
| rdata | output | 8 | Captured counter value |
| aux_in | input | 1 | Asynchronous event input |
| timeout | output | 1 | One-cycle pulse after each pass from 01 |
| out_line | output | 1 | Output line, toggled on each pass from 01 |

## Verification
The assertions check the following on every cycle:
- the timeout pulse lasts one cycle and follows every pass from 01;
- out_line toggles on each pass from 01 unless a clear wins;
- the counter holds while stopped and between ticks;
- the counter and reload register load together while stopped;
- the prescaler clears while it is disabled;
- event pulses never appear back to back;
- rdata changes only on a strobe edge.

Only the bench scenarios can show the following:
- the tick period of each mode code;
- the 256-tick period of a zero reload;
- correct edge polarity;
- the count caused by flipping the polarity bit;
- that a held write reaches the counter at the right pass, including the write that lands on the pass itself.

The bench follows these through a tick-level model of counter, reload value, timeout count and output line.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 7;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    M_STOP = 3'd0,
    M_D4   = 3'd1,
    M_D10  = 3'd2,
    M_D16  = 3'd3,
    M_D50  = 3'd4,
    M_D64  = 3'd5,
    M_D100 = 3'd6,
    M_EVT  = 3'd7
  } tmr_mode_e;

  // Last prescaler state before a tick (period minus one).
  function automatic int unsigned presc_limit(input tmr_mode_e m);
    case (m)
      M_D4:    return 3;
      M_D10:   return 9;
      M_D16:   return 15;
      M_D50:   return 49;
      M_D64:   return 63;
      M_D100:  return 99;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_delay(input tmr_mode_e m);
    return (m != M_STOP) && (m != M_EVT);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PRE_W = tmr_pkg::PRE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  tmr_pkg::tmr_mode_e  mode_i,
  output logic                tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  assign limit  = PRE_W'(tmr_pkg::presc_limit(mode_i));
  assign tick_o = en_i && (pre_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (!en_i || tick_o)  pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end

  // R4: prescaler restarts while disabled
  a_r4_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pre_q == '0));
endmodule

// File: rtl/tmr_edge_det.sv
`timescale 1ns/1ps
module tmr_edge_det #(
  parameter int SYNC_STAGES = tmr_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aux_i,
  input  logic pol_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl;
  logic                   lvl_q;

  // Polarity folded into the level: a rise of lvl is the selected edge.
  assign lvl     = sync_q[SYNC_STAGES-1] ^ ~pol_i;
  assign pulse_o = lvl & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], aux_i};
      lvl_q  <= lvl;
    end
  end

  // R5: a detected edge lasts one cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
  parameter int W = tmr_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_out_i,
  output logic [W-1:0] cnt_o,
  output logic         timeout_o,
  output logic         out_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] dreg_q;
  logic         timeout_q;
  logic         out_q;
  logic         pass01;
  logic [W-1:0] reload_val;

  assign pass01     = run_i && tick_i && (cnt_q == ONE);
  assign reload_val = wr_i ? wdata_i : dreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      dreg_q    <= '0;
      timeout_q <= 1'b0;
      out_q     <= 1'b0;
    end else begin
      if (wr_i) dreg_q <= wdata_i;
      if (!run_i) begin
        if (wr_i) cnt_q <= wdata_i;
      end else if (tick_i) begin
        cnt_q <= pass01 ? reload_val : cnt_q - 1'b1;
      end
      timeout_q <= pass01;
      if (clr_out_i)   out_q <= 1'b0;
      else if (pass01) out_q <= ~out_q;
    end
  end

  assign cnt_o     = cnt_q;
  assign timeout_o = timeout_q;
  assign out_o     = out_q;

  // R2: stopped write loads counter and reload register together
  a_r2_stop_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && wr_i) |=> (cnt_q == $past(wdata_i)) && (dreg_q == $past(wdata_i)));
  // R3: running counter moves only on ticks
  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(cnt_q));
  // R7: timeout follows each pass from 01 and lasts one cycle
  a_r7_timeout_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pass01 |=> timeout_q);
  a_r7_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_q |=> !timeout_q);
  a_r7_out_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (pass01 && !clr_out_i) |=> (out_q != $past(out_q)));
  // R10: clear wins
  a_r10_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
    clr_out_i |=> !out_q);
  // R11: stopped counter holds without a write
  a_r11_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_i) |=> ($stable(cnt_q) && !timeout_q));
endmodule

// File: rtl/evt_dly_timer.sv
`timescale 1ns/1ps
module evt_dly_timer #(
  parameter int W           = tmr_pkg::CNT_W,
  parameter int PRE_W       = tmr_pkg::PRE_W,
  parameter int SYNC_STAGES = tmr_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  input  logic         rd_strobe,
  output logic [W-1:0] rdata,
  input  logic         aux_in,
  output logic         timeout,
  output logic         out_line
);
  import tmr_pkg::*;

  localparam int POL_BIT = 3;
  localparam int CLR_BIT = 4;

  tmr_mode_e    mode_q;
  logic         pol_q;
  logic         strobe_q;
  logic [W-1:0] rd_q;
  logic [W-1:0] cnt;
  logic         running;
  logic         pre_tick;
  logic         evt_pulse;
  logic         tick;
  logic         clr_out;
  logic         strobe_rise;

  assign running     = (mode_q != M_STOP);
  assign tick        = (mode_q == M_EVT) ? evt_pulse : pre_tick;
  assign clr_out     = wr_ctrl && wdata[CLR_BIT];
  assign strobe_rise = rd_strobe && !strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_STOP;
      pol_q    <= 1'b0;
      strobe_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= tmr_mode_e'(wdata[2:0]);
        pol_q  <= wdata[POL_BIT];
      end
      strobe_q <= rd_strobe;
      if (strobe_rise) rd_q <= cnt;
    end
  end

  tmr_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (is_delay(mode_q)),
    .mode_i (mode_q),
    .tick_o (pre_tick)
  );

  tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .aux_i   (aux_in),
    .pol_i   (pol_q),
    .pulse_o (evt_pulse)
  );

  tmr_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (running),
    .tick_i    (tick),
    .wr_i      (wr_data),
    .wdata_i   (wdata),
    .clr_out_i (clr_out),
    .cnt_o     (cnt),
    .timeout_o (timeout),
    .out_o     (out_line)
  );

  assign rdata = rd_q;

  // R9: read register changes only on a strobe rising edge
  a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_rise |=> $stable(rd_q));
  // R11: no tick source acts while stopped
  a_r11_no_run_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pre_tick);
endmodule

// File: tb/evt_dly_timer_tb.sv
`timescale 1ns/1ps
module evt_dly_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_data = 1'b0, wr_ctrl = 1'b0, rd_strobe = 1'b0, aux_in = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       timeout, out_line;

  int total = 0, bad = 0, to_seen = 0;
  bit finished = 0;

  // model state
  logic [7:0] m_cnt = 0, m_dreg = 0;
  int         m_to = 0;
  logic       m_out = 0, m_pol = 0;

  always #2 clk = ~clk;

  evt_dly_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .wdata(wdata), .rd_strobe(rd_strobe), .rdata(rdata), .aux_in(aux_in),
    .timeout(timeout), .out_line(out_line)
  );

  always @(negedge clk) if (rst_n && timeout) to_seen++;

  function automatic int period_of(input int code);
    int p[8] = '{0, 4, 10, 16, 50, 64, 100, 0};
    return p[code];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic put_ctrl(input logic [7:0] v);
    wdata = v; wr_ctrl = 1; @(posedge clk); @(negedge clk); wr_ctrl = 0;
  endtask

  task automatic put_data(input logic [7:0] v);
    wdata = v; wr_data = 1; @(posedge clk); @(negedge clk); wr_data = 0;
  endtask

  task automatic read_cnt(output logic [7:0] v);
    rd_strobe = 1; @(posedge clk); @(negedge clk); rd_strobe = 0;
    v = rdata;
    idle(1);
  endtask

  // running-tick model step
  task automatic m_step(input bit tk, input bit wr, input logic [7:0] v);
    if (wr) m_dreg = v;
    if (tk) begin
      if (m_cnt == 8'd1) begin m_cnt = m_dreg; m_to++; m_out = !m_out; end
      else m_cnt = m_cnt - 8'd1;
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    read_cnt(v);
    check(v == m_cnt, req, v, m_cnt);
    check(to_seen == m_to, {req, " timeouts"}, to_seen, m_to);
    check(out_line == m_out, {req, " out_line"}, out_line, m_out);
  endtask

  task automatic stop_load(input logic [7:0] v, input bit clr);
    put_ctrl({3'b0, clr, m_pol, 3'd0});
    if (clr) m_out = 0;
    put_data(v);
    m_cnt = v; m_dreg = v;
  endtask

  // run delay mode for m cycles; optional data write at edge wr_at
  task automatic run_delay(input int code, input int m, input int wr_at, input logic [7:0] v);
    int p = period_of(code);
    put_ctrl({4'b0, m_pol, code[2:0]});
    for (int j = 1; j < m; j++) begin
      if (j == wr_at) put_data(v); else idle(1);
    end
    put_ctrl({4'b0, m_pol, 3'd0});
    for (int j = 1; j <= m; j++) m_step((j % p) == 0, j == wr_at, v);
    idle(1);
  endtask

  task automatic evt_enter();
    put_ctrl({4'b0, m_pol, 3'd7});
    idle(1);
  endtask

  task automatic evt_flip_aux();
    aux_in = !aux_in;
    idle(5);
    if (aux_in == m_pol) m_step(1, 0, 0);
  endtask

  task automatic evt_flip_pol();
    m_pol = !m_pol;
    put_ctrl({4'b0, m_pol, 3'd7});
    idle(4);
    if (aux_in == m_pol) m_step(1, 0, 0);
  endtask

  task automatic evt_leave();
    put_ctrl({4'b0, m_pol, 3'd0});
    idle(2);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, held;
    int base;
    void'($urandom(32'h5EED_1234));
    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset state
    check(rdata == 0, "R1 rdata", rdata, 0);
    check(timeout == 0, "R1 timeout", timeout, 0);
    check(out_line == 0, "R1 out_line", out_line, 0);
    check_all("R1 counter after reset");

    // R2 stopped load
    stop_load(8'h05, 0);
    check_all("R2 stopped load");

    // R4 prescaler restart: two 7-cycle runs of period 10 give no tick
    run_delay(2, 7, 0, 0);
    run_delay(2, 7, 0, 0);
    check_all("R4 prescaler cleared while stopped");

    // R4 each period: 3 ticks in 3*p+1 cycles
    for (int c = 1; c <= 6; c++) begin
      stop_load(8'h20, 0);
      run_delay(c, 3 * period_of(c) + 1, 0, 0);
      check(m_cnt == 8'h1D, "R4 model", m_cnt, 8'h1D);
      check_all("R4 delay period");
    end

    // R3 running write held
    stop_load(8'h10, 0);
    run_delay(1, 20, 2, 8'h03);
    check_all("R3 held write not in counter");
    run_delay(1, 48, 0, 0);
    check_all("R3 held write used at reload");

    // R3/R7 write coinciding with pass from 01: new value wins
    stop_load(8'h01, 0);
    base = to_seen;
    run_delay(1, 6, 4, 8'h33);
    check_all("R3 coincident write wins");
    check(to_seen == base + 1, "R7 one timeout", to_seen, base + 1);

    // R8 zero reload = 256 ticks
    stop_load(8'h00, 0);
    base = to_seen;
    run_delay(1, 4 * 255, 0, 0);
    check_all("R8 255 ticks");
    check(to_seen == base, "R8 no timeout yet", to_seen, base);
    run_delay(1, 4, 0, 0);
    check_all("R8 256th tick");
    check(to_seen == base + 1, "R8 timeout at 256", to_seen, base + 1);

    // R5 rising edges with polarity 1, falling with 0
    m_pol = 1;
    stop_load(8'h09, 0);
    evt_enter();
    for (int i = 0; i < 6; i++) evt_flip_aux();
    evt_leave();
    check_all("R5 rising edge count");
    m_pol = 0;
    stop_load(8'h09, 0);
    evt_enter();
    for (int i = 0; i < 5; i++) evt_flip_aux();
    evt_leave();
    check_all("R5 falling edge count");

    // R6 polarity flip counts
    stop_load(8'h40, 0);
    evt_enter();
    evt_flip_pol();
    evt_flip_pol();
    evt_flip_pol();
    evt_leave();
    check_all("R6 polarity flip count");

    // R9 read holds without strobe
    read_cnt(held);
    run_delay(1, 40, 0, 0);
    check(rdata == held, "R9 rdata holds", rdata, held);
    check_all("R9 fresh capture");

    // R10 clear output line
    if (!m_out) begin stop_load(8'h01, 0); run_delay(1, 4, 0, 0); end
    check(out_line == 1, "R10 precondition", out_line, 1);
    stop_load(8'h07, 1);
    check(out_line == 0, "R10 cleared", out_line, 0);
    check_all("R10 after clear");

    // R11 stopped holds
    base = to_seen;
    idle(50);
    check_all("R11 stopped hold");
    check(to_seen == base, "R11 no timeout", to_seen, base);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: stop_load(8'($urandom_range(0, 255)), bit'($urandom_range(0, 1)));
        1: begin
          int c = $urandom_range(1, 6);
          int m = $urandom_range(2, 300);
          run_delay(c, m, $urandom_range(0, m - 1), 8'($urandom_range(0, 255)));
        end
        2: begin
          evt_enter();
          for (int k = 0; k < $urandom_range(1, 12); k++) begin
            if ($urandom_range(0, 3) == 0) evt_flip_pol(); else evt_flip_aux();
          end
          evt_leave();
        end
        default: stop_load(8'($urandom_range(1, 4)), 0);
      endcase
      check_all("R3 R7 random mix");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule